// File: doc/BRIEF.md
# Pad Ownership and Function Multiplexer

This block sits between 38 general-purpose pads and the logic that wants to use them. For every pad it decides who drives the pad output and its output-disable, and who sees the pad input. The choice follows a fixed order. The user project owns any pad whose management-enable configuration bit is clear. A pad under management control is driven by its dedicated special function when that function is enabled. Otherwise it is driven by a bit of the management data register.

The block holds the management data outputs in two words: a 32-bit low word for pads 0..31 and a 6-bit high word for pads 32..37. A low-word write that leaves out the top byte goes into a staging register and takes effect only when a later write includes the top byte. Reads of either data word return the live pad inputs, not the written values.

The block also holds three small special-function enable registers: a housekeeping serial-port disable, a monitor select and an interrupt-source select. The serial-port and SPI-master enables arrive as input signals. The per-pad configuration bits (management enable, output disable, input disable) come from the pad configuration chain as static inputs.

Top module: `pad_owner_mux`

## Requirements
- R1: When `padMgmtEn[i]` is 0, `padOut[i]` equals `userOut[i]`, `padOeb[i]` equals `userOeb[i]`, and `userIn[i]` equals `padIn[i]` (unless input is disabled). An output-disable value of 1 turns the pad driver off; 0 drives the pad.
- R2: When `padMgmtEn[i]` is 1 and pad i has no enabled special function, `padOut[i]` is data register bit i, `padOeb[i]` equals `padOutDis[i]`, and `userIn[i]` is 0.
- R3: When `padMgmtEn[i]` is 1 and pad i's special function is enabled, that function drives `padOut[i]` and `padOeb[i]`. An input-type function receives the pad value with `padOeb[i]`=1. The data register bit has no effect on the pad.
- R4: Reading address 0 returns pads 31..0 and reading address 1 returns pads 37..32 in bits 5..0, with upper bits zero. Both return the live pad inputs, not the last written data.
- R5: A write to address 0 with `regByteEn[3]`=0 updates only the staging bytes it enables and leaves the pads unchanged. A later address-0 write with `regByteEn[3]`=1 applies the staged bytes merged with its own enabled bytes, one cycle after the write edge.
- R6: A write to address 1 with `regByteEn[0]`=1 updates the data bits of pads 32..37 from `regWdata[5:0]` at that edge.
- R7: Address 2 bit 0 is the housekeeping disable (reset 0). While it is 0, pads 1..4 carry the housekeeping serial port. Pad 1 is driven by `hkSdo` with output-disable `hkSdoOeb`. Pads 2, 3 and 4 are inputs feeding `hkSdi`, `hkCsb` and `hkSck`.
- R8: Address 3 holds the monitor select. Bit 0 puts `trapIn` on pad 13, bit 1 puts `userClk` on pad 15, and bit 2 puts `coreClk` on pad 14, each with the driver on.
- R9: Address 4 holds the interrupt-source select. Bit 0 makes pad 7 an input feeding `irq1`, and bit 1 makes pad 12 an input feeding `irq2`.
- R10: While `uartEnable` is 1, pad 5 feeds `uartRx` and pad 6 is driven by `uartTx`. While `spiEnable` is 1, pads 32, 33 and 35 are driven by `spiSck`, `spiCsb` and `spiSdo`, and pad 34 feeds `spiSdi`.
- R11: A pad with `padInDis[i]`=1 returns 0 on `userIn[i]`, on its special-function input and in the data readback.
- R12: After reset the data, staging and enable registers are 0. Addresses 2, 3 and 4 read back their register values in the low bits, and special inputs whose pad is not routed to them read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrite | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address (0 data low, 1 data high, 2 hk disable, 3 monitor, 4 irq) |
| regByteEn | input | 4 | Byte enables of the write |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr` (combinational) |
| padMgmtEn | input | 38 | Per-pad management enable |
| padOutDis | input | 38 | Per-pad output disable used under plain management control |
| padInDis | input | 38 | Per-pad input disable |
| userOut | input | 38 | User project output values |
| userOeb | input | 38 | User project output disables |
| userIn | output | 38 | Pad values delivered to the user project |
| padIn | input | 38 | Pad input values |
| padOut | output | 38 | Pad output values |
| padOeb | output | 38 | Pad output disables (1 = driver off) |
| uartEnable | input | 1 | Serial port enable |
| spiEnable | input | 1 | SPI master enable |
| hkSdo | input | 1 | Housekeeping serial data out |
| hkSdoOeb | input | 1 | Housekeeping serial data out disable |
| hkSdi | output | 1 | Housekeeping serial data in |
| hkCsb | output | 1 | Housekeeping chip select |
| hkSck | output | 1 | Housekeeping serial clock |
| uartRx | output | 1 | Serial port receive |
| uartTx | input | 1 | Serial port transmit |
| irq1 | output | 1 | Interrupt line from pad 7 |
| irq2 | output | 1 | Interrupt line from pad 12 |
| trapIn | input | 1 | CPU trap state to monitor |
| coreClk | input | 1 | Core clock to monitor |
| userClk | input | 1 | User clock to monitor |
| spiSck | input | 1 | SPI master clock |
| spiCsb | input | 1 | SPI master chip select |
| spiSdo | input | 1 | SPI master data out |
| spiSdi | output | 1 | SPI master data in |

## Verification
The assertions check several properties on every cycle. User-owned pads always pass the user output and disable through. No input-disabled pad ever leaks onto the user inputs. The low-word readback always equals the live enabled pad inputs. A staged partial write never moves the pads. A high-word write lands in the next cycle. The bench scenarios are needed to show the precedence between the special functions and plain management data for every combination of the eight function enables. They also show the merge of several staged bytes into one committed word and the gating of each named special input.

// File: rtl/pad_mux_pkg.sv
package pad_mux_pkg;

  localparam int ADDR_W   = 3;
  localparam int WORD_W   = 32;
  localparam int BYTES    = WORD_W / 8;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_DATA_LO = 3'd0,
    ADDR_DATA_HI = 3'd1,
    ADDR_HK_DIS  = 3'd2,
    ADDR_MON     = 3'd3,
    ADDR_IRQ     = 3'd4
  } regAddrE;

  // Pad positions decoded by the pad-side wiring of each function.
  localparam int PAD_HK_SDO   = 1;
  localparam int PAD_HK_SDI   = 2;
  localparam int PAD_HK_CSB   = 3;
  localparam int PAD_HK_SCK   = 4;
  localparam int PAD_UART_RX  = 5;
  localparam int PAD_UART_TX  = 6;
  localparam int PAD_IRQ_A    = 7;
  localparam int PAD_IRQ_B    = 12;
  localparam int PAD_TRAP     = 13;
  localparam int PAD_CORE_CLK = 14;
  localparam int PAD_USER_CLK = 15;
  localparam int PAD_SPI_SCK  = 32;
  localparam int PAD_SPI_CSB  = 33;
  localparam int PAD_SPI_SDI  = 34;
  localparam int PAD_SPI_SDO  = 35;

  // Strobes from the register decoder to the register datapath.
  typedef struct packed {
    logic [BYTES-1:0] lowBytes;
    logic             stageLow;
    logic             commitLow;
    logic             wrHigh;
    logic             wrHkDis;
    logic             wrMon;
    logic             wrIrq;
  } regStrobeT;

endpackage

// File: rtl/pad_mux_ctrl.sv
module pad_mux_ctrl
  import pad_mux_pkg::*;
(
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BYTES-1:0]  regByteEn,
  output regStrobeT         strobes
);

  logic lowHit;
  assign lowHit = regWrite && (regAddr == ADDR_DATA_LO);

  always_comb begin
    strobes           = '0;
    strobes.lowBytes  = regByteEn;
    strobes.stageLow  = lowHit && (regByteEn != '0);
    strobes.commitLow = lowHit && regByteEn[BYTES-1];
    strobes.wrHigh    = regWrite && (regAddr == ADDR_DATA_HI) && regByteEn[0];
    strobes.wrHkDis   = regWrite && (regAddr == ADDR_HK_DIS)  && regByteEn[0];
    strobes.wrMon     = regWrite && (regAddr == ADDR_MON)     && regByteEn[0];
    strobes.wrIrq     = regWrite && (regAddr == ADDR_IRQ)     && regByteEn[0];
  end

endmodule

// File: rtl/pad_mux_regs.sv
module pad_mux_regs
  import pad_mux_pkg::*;
#(
  parameter int NUM_PADS = 38
) (
  input  logic                clk,
  input  logic                rstN,
  input  regStrobeT           strobes,
  input  logic [WORD_W-1:0]   regWdata,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [NUM_PADS-1:0] mgmtIn,
  output logic [WORD_W-1:0]   regRdata,
  output logic [NUM_PADS-1:0] dataOut,
  output logic                hkDisable,
  output logic [2:0]          monSel,
  output logic [1:0]          irqSel
);

  localparam int HI_W = NUM_PADS - WORD_W;

  logic [WORD_W-1:0] stageLow;
  logic [WORD_W-1:0] mergedLow;
  logic [WORD_W-1:0] dataLow;
  logic [HI_W-1:0]   dataHigh;

  // Merge enabled bytes of the write over the staged bytes.
  for (genvar b = 0; b < BYTES; b++) begin : g_mergeByte
    assign mergedLow[8*b +: 8] = strobes.lowBytes[b] ? regWdata[8*b +: 8]
                                                     : stageLow[8*b +: 8];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageLow  <= '0;
      dataLow   <= '0;
      dataHigh  <= '0;
      hkDisable <= 1'b0;
      monSel    <= '0;
      irqSel    <= '0;
    end else begin
      if (strobes.stageLow)  stageLow  <= mergedLow;
      if (strobes.commitLow) dataLow   <= mergedLow;
      if (strobes.wrHigh)    dataHigh  <= regWdata[HI_W-1:0];
      if (strobes.wrHkDis)   hkDisable <= regWdata[0];
      if (strobes.wrMon)     monSel    <= regWdata[2:0];
      if (strobes.wrIrq)     irqSel    <= regWdata[1:0];
    end
  end

  assign dataOut = {dataHigh, dataLow};

  always_comb begin
    case (regAddr)
      ADDR_DATA_LO: regRdata = mgmtIn[WORD_W-1:0];
      ADDR_DATA_HI: regRdata = {{(WORD_W-HI_W){1'b0}}, mgmtIn[NUM_PADS-1:WORD_W]};
      ADDR_HK_DIS:  regRdata = {{(WORD_W-1){1'b0}}, hkDisable};
      ADDR_MON:     regRdata = {{(WORD_W-3){1'b0}}, monSel};
      ADDR_IRQ:     regRdata = {{(WORD_W-2){1'b0}}, irqSel};
      default:      regRdata = '0;
    endcase
  end

  // A staged partial write must leave the driven low word untouched.
  assert_stage_holds_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.stageLow && !strobes.commitLow) |=> $stable(dataOut[WORD_W-1:0]));

  // A high-word write lands at the next edge.
  assert_high_lands_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrHigh |=> (dataOut[NUM_PADS-1:WORD_W] == $past(regWdata[HI_W-1:0])));

endmodule

// File: rtl/pad_mux_route.sv
module pad_mux_route
  import pad_mux_pkg::*;
#(
  parameter int NUM_PADS = 38
) (
  input  logic [NUM_PADS-1:0] mgmtEn,
  input  logic [NUM_PADS-1:0] outDis,
  input  logic [NUM_PADS-1:0] inDis,
  input  logic [NUM_PADS-1:0] padIn,
  input  logic [NUM_PADS-1:0] userOut,
  input  logic [NUM_PADS-1:0] userOeb,
  input  logic [NUM_PADS-1:0] dataOut,
  input  logic                hkDisable,
  input  logic [2:0]          monSel,
  input  logic [1:0]          irqSel,
  input  logic                uartEnable,
  input  logic                spiEnable,
  input  logic                hkSdo,
  input  logic                hkSdoOeb,
  input  logic                uartTx,
  input  logic                trapIn,
  input  logic                coreClk,
  input  logic                userClk,
  input  logic                spiSck,
  input  logic                spiCsb,
  input  logic                spiSdo,
  output logic [NUM_PADS-1:0] padOut,
  output logic [NUM_PADS-1:0] padOeb,
  output logic [NUM_PADS-1:0] userIn,
  output logic [NUM_PADS-1:0] mgmtIn,
  output logic                hkSdi,
  output logic                hkCsb,
  output logic                hkSck,
  output logic                uartRx,
  output logic                irq1,
  output logic                irq2,
  output logic                spiSdi
);

  logic [NUM_PADS-1:0] sfEn;
  logic [NUM_PADS-1:0] sfOut;
  logic [NUM_PADS-1:0] sfOeb;
  logic [NUM_PADS-1:0] padLive;
  logic [NUM_PADS-1:0] sfOwn;

  // Per-pad special function table: enable, driven value, driver disable.
  always_comb begin
    sfEn  = '0;
    sfOut = '0;
    sfOeb = '1;
    for (int p = PAD_HK_SDO; p <= PAD_HK_SCK; p++) sfEn[p] = !hkDisable;
    sfOut[PAD_HK_SDO]   = hkSdo;
    sfOeb[PAD_HK_SDO]   = hkSdoOeb;
    sfEn[PAD_UART_RX]   = uartEnable;
    sfEn[PAD_UART_TX]   = uartEnable;
    sfOut[PAD_UART_TX]  = uartTx;
    sfOeb[PAD_UART_TX]  = 1'b0;
    sfEn[PAD_IRQ_A]     = irqSel[0];
    sfEn[PAD_IRQ_B]     = irqSel[1];
    sfEn[PAD_TRAP]      = monSel[0];
    sfOut[PAD_TRAP]     = trapIn;
    sfOeb[PAD_TRAP]     = 1'b0;
    sfEn[PAD_USER_CLK]  = monSel[1];
    sfOut[PAD_USER_CLK] = userClk;
    sfOeb[PAD_USER_CLK] = 1'b0;
    sfEn[PAD_CORE_CLK]  = monSel[2];
    sfOut[PAD_CORE_CLK] = coreClk;
    sfOeb[PAD_CORE_CLK] = 1'b0;
    for (int p = PAD_SPI_SCK; p <= PAD_SPI_SDO; p++) sfEn[p] = spiEnable;
    sfOut[PAD_SPI_SCK]  = spiSck;
    sfOeb[PAD_SPI_SCK]  = 1'b0;
    sfOut[PAD_SPI_CSB]  = spiCsb;
    sfOeb[PAD_SPI_CSB]  = 1'b0;
    sfOut[PAD_SPI_SDO]  = spiSdo;
    sfOeb[PAD_SPI_SDO]  = 1'b0;
  end

  for (genvar g = 0; g < NUM_PADS; g++) begin : g_padLane
    assign padLive[g] = padIn[g] & ~inDis[g];
    assign sfOwn[g]   = mgmtEn[g] & sfEn[g];
    always_comb begin
      if (!mgmtEn[g]) begin
        padOut[g] = userOut[g];
        padOeb[g] = userOeb[g];
      end else if (sfEn[g]) begin
        padOut[g] = sfOut[g];
        padOeb[g] = sfOeb[g];
      end else begin
        padOut[g] = dataOut[g];
        padOeb[g] = outDis[g];
      end
    end
    assign userIn[g] = ~mgmtEn[g] & padLive[g];
    assign mgmtIn[g] = padLive[g];
  end

  assign hkSdi  = sfOwn[PAD_HK_SDI]  & padLive[PAD_HK_SDI];
  assign hkCsb  = sfOwn[PAD_HK_CSB]  & padLive[PAD_HK_CSB];
  assign hkSck  = sfOwn[PAD_HK_SCK]  & padLive[PAD_HK_SCK];
  assign uartRx = sfOwn[PAD_UART_RX] & padLive[PAD_UART_RX];
  assign irq1   = sfOwn[PAD_IRQ_A]   & padLive[PAD_IRQ_A];
  assign irq2   = sfOwn[PAD_IRQ_B]   & padLive[PAD_IRQ_B];
  assign spiSdi = sfOwn[PAD_SPI_SDI] & padLive[PAD_SPI_SDI];

endmodule

// File: rtl/pad_owner_mux.sv
module pad_owner_mux
  import pad_mux_pkg::*;
#(
  parameter int NUM_PADS = 38
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrite,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [BYTES-1:0]    regByteEn,
  input  logic [WORD_W-1:0]   regWdata,
  output logic [WORD_W-1:0]   regRdata,
  input  logic [NUM_PADS-1:0] padMgmtEn,
  input  logic [NUM_PADS-1:0] padOutDis,
  input  logic [NUM_PADS-1:0] padInDis,
  input  logic [NUM_PADS-1:0] userOut,
  input  logic [NUM_PADS-1:0] userOeb,
  output logic [NUM_PADS-1:0] userIn,
  input  logic [NUM_PADS-1:0] padIn,
  output logic [NUM_PADS-1:0] padOut,
  output logic [NUM_PADS-1:0] padOeb,
  input  logic                uartEnable,
  input  logic                spiEnable,
  input  logic                hkSdo,
  input  logic                hkSdoOeb,
  output logic                hkSdi,
  output logic                hkCsb,
  output logic                hkSck,
  output logic                uartRx,
  input  logic                uartTx,
  output logic                irq1,
  output logic                irq2,
  input  logic                trapIn,
  input  logic                coreClk,
  input  logic                userClk,
  input  logic                spiSck,
  input  logic                spiCsb,
  input  logic                spiSdo,
  output logic                spiSdi
);

  regStrobeT           strobes;
  logic [NUM_PADS-1:0] dataOut;
  logic [NUM_PADS-1:0] mgmtIn;
  logic                hkDisable;
  logic [2:0]          monSel;
  logic [1:0]          irqSel;

  pad_mux_ctrl i_ctrl (
    .regWrite (regWrite),
    .regAddr  (regAddr),
    .regByteEn(regByteEn),
    .strobes  (strobes)
  );

  pad_mux_regs #(.NUM_PADS(NUM_PADS)) i_regs (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .regWdata (regWdata),
    .regAddr  (regAddr),
    .mgmtIn   (mgmtIn),
    .regRdata (regRdata),
    .dataOut  (dataOut),
    .hkDisable(hkDisable),
    .monSel   (monSel),
    .irqSel   (irqSel)
  );

  pad_mux_route #(.NUM_PADS(NUM_PADS)) i_route (
    .mgmtEn    (padMgmtEn),
    .outDis    (padOutDis),
    .inDis     (padInDis),
    .padIn     (padIn),
    .userOut   (userOut),
    .userOeb   (userOeb),
    .dataOut   (dataOut),
    .hkDisable (hkDisable),
    .monSel    (monSel),
    .irqSel    (irqSel),
    .uartEnable(uartEnable),
    .spiEnable (spiEnable),
    .hkSdo     (hkSdo),
    .hkSdoOeb  (hkSdoOeb),
    .uartTx    (uartTx),
    .trapIn    (trapIn),
    .coreClk   (coreClk),
    .userClk   (userClk),
    .spiSck    (spiSck),
    .spiCsb    (spiCsb),
    .spiSdo    (spiSdo),
    .padOut    (padOut),
    .padOeb    (padOeb),
    .userIn    (userIn),
    .mgmtIn    (mgmtIn),
    .hkSdi     (hkSdi),
    .hkCsb     (hkCsb),
    .hkSck     (hkSck),
    .uartRx    (uartRx),
    .irq1      (irq1),
    .irq2      (irq2),
    .spiSdi    (spiSdi)
  );

  // User-owned pads pass the user output and disable straight through.
  assert_user_owns_R1: assert property (@(posedge clk) disable iff (!rstN)
    (((padOut ^ userOut) | (padOeb ^ userOeb)) & ~padMgmtEn) == '0);

  // Low-word readback is the live enabled pad input.
  assert_readback_live_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_DATA_LO) |-> (regRdata == (padIn[WORD_W-1:0] & ~padInDis[WORD_W-1:0])));

  // Input-disabled pads never reach the user project.
  assert_indis_blocks_R11: assert property (@(posedge clk) disable iff (!rstN)
    (userIn & padInDis) == '0);

endmodule

// File: tb/test_pad_owner_mux.sv
module test_pad_owner_mux;

  localparam int CLK_PERIOD = 10;
  localparam int N = 38;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrite = 1'b0;
  logic [2:0] regAddr = '0;
  logic [3:0] regByteEn = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [N-1:0] padMgmtEn = '0, padOutDis = '0, padInDis = '0;
  logic [N-1:0] userOut = '0, userOeb = '0, padIn = '0;
  logic [N-1:0] userIn, padOut, padOeb;
  logic uartEnable = 0, spiEnable = 0, hkSdo = 0, hkSdoOeb = 0, uartTx = 0;
  logic trapIn = 0, coreClk = 0, userClk = 0, spiSck = 0, spiCsb = 0, spiSdo = 0;
  logic hkSdi, hkCsb, hkSck, uartRx, irq1, irq2, spiSdi;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  logic [31:0] seed = 32'h1234_5678;

  // Bench model of the register state.
  logic [N-1:0] mData = '0;
  logic [31:0] mStage = '0;
  logic mHkDis = 0;
  logic [2:0] mMon = '0;
  logic [1:0] mIrq = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pad_owner_mux i_pad_owner_mux (.*);

  function automatic logic [31:0] nextRand(input logic [31:0] s);
    return s * 32'd1103515245 + 32'd12345;
  endfunction

  task automatic rnd38(output logic [N-1:0] v);
    logic [31:0] a;
    seed = nextRand(seed); a = seed;
    seed = nextRand(seed);
    v = {seed[21:16], a[31:16], seed[31:22], a[9:4]};
  endtask

  function automatic logic sfEnM(int i);
    case (i)
      1, 2, 3, 4:     return !mHkDis;
      5, 6:           return uartEnable;
      7:              return mIrq[0];
      12:             return mIrq[1];
      13:             return mMon[0];
      14:             return mMon[2];
      15:             return mMon[1];
      32, 33, 34, 35: return spiEnable;
      default:        return 1'b0;
    endcase
  endfunction

  function automatic logic sfOutM(int i);
    case (i)
      1: return hkSdo;   6: return uartTx;  13: return trapIn;
      14: return coreClk; 15: return userClk; 32: return spiSck;
      33: return spiCsb; 35: return spiSdo;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic sfOebM(int i);
    case (i)
      1: return hkSdoOeb;
      6, 13, 14, 15, 32, 33, 35: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic sfInM(int i);
    return padIn[i] & ~padInDis[i] & padMgmtEn[i] & sfEnM(i);
  endfunction

  task automatic check(input string tag, input string what, input logic [63:0] got, input logic [63:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic checkPads(input string tag);
    logic [N-1:0] eOut, eOeb, eIn, live;
    live = padIn & ~padInDis;
    for (int i = 0; i < N; i++) begin
      if (!padMgmtEn[i]) begin eOut[i] = userOut[i]; eOeb[i] = userOeb[i]; end
      else if (sfEnM(i)) begin eOut[i] = sfOutM(i); eOeb[i] = sfOebM(i); end
      else begin eOut[i] = mData[i]; eOeb[i] = padOutDis[i]; end
    end
    eIn = live & ~padMgmtEn;
    check(tag, "padOut", 64'(padOut), 64'(eOut));
    check(tag, "padOeb", 64'(padOeb), 64'(eOeb));
    check(tag, "userIn", 64'(userIn), 64'(eIn));
    check(tag, "specialIn", 64'({hkSdi, hkCsb, hkSck, uartRx, irq1, irq2, spiSdi}),
          64'({sfInM(2), sfInM(3), sfInM(4), sfInM(5), sfInM(7), sfInM(12), sfInM(34)}));
    regAddr = 3'd0; #1;
    check("R4", "readLow", 64'(regRdata), 64'(live[31:0]));
    regAddr = 3'd1; #1;
    check("R4", "readHigh", 64'(regRdata), {58'd0, live[37:32]});
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    regWrite = 1; regAddr = a; regByteEn = be; regWdata = d;
    @(negedge clk);
    regWrite = 0; regByteEn = '0;
    if (a == 3'd0) begin
      for (int b = 0; b < 4; b++) if (be[b]) mStage[8*b +: 8] = d[8*b +: 8];
      if (be[3]) mData[31:0] = mStage;
    end else if (be[0]) begin
      case (a)
        3'd1: mData[37:32] = d[5:0];
        3'd2: mHkDis = d[0];
        3'd3: mMon = d[2:0];
        3'd4: mIrq = d[1:0];
        default: ;
      endcase
    end
    #1;
  endtask

  task automatic readReg(input string tag, input logic [2:0] a, input logic [31:0] exp);
    regAddr = a; #1;
    check(tag, "readReg", 64'(regRdata), 64'(exp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] v;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk); #1;

    // R12: reset state of registers and outputs.
    readReg("R12", 3'd2, 32'd0);
    readReg("R12", 3'd3, 32'd0);
    readReg("R12", 3'd4, 32'd0);
    padMgmtEn = '1; #1;
    checkPads("R12 R7");

    // R1: user ownership under varied patterns.
    padMgmtEn = '0;
    for (int k = 0; k < 20; k++) begin
      rnd38(v); userOut = v; rnd38(v); userOeb = v; rnd38(v); padIn = v;
      #1; checkPads("R1");
    end

    // R2 R6: plain management data, housekeeping port off.
    padMgmtEn = '1;
    busWrite(3'd2, 4'h1, 32'd1);
    for (int k = 0; k < 8; k++) begin
      rnd38(v); padOutDis = v; rnd38(v); padIn = v;
      seed = nextRand(seed);
      busWrite(3'd0, 4'hF, seed);
      busWrite(3'd1, 4'h1, {26'd0, seed[11:6]});
      checkPads("R2 R6");
    end

    // R5: partial low writes stage, full write commits merged word.
    busWrite(3'd0, 4'hF, 32'hA5A5_A5A5);
    busWrite(3'd0, 4'h1, 32'h0000_0011);
    checkPads("R5");
    busWrite(3'd0, 4'h6, 32'h0033_2200);
    check("R5", "heldLow", 64'(padOut[31:0] & ~32'd0), 64'(32'hA5A5_A5A5));
    busWrite(3'd0, 4'h8, 32'h4400_0000);
    check("R5", "commitLow", 64'(padOut[31:0]), 64'(32'h4433_2211));
    checkPads("R5");

    // R3 R7 R8 R9 R10: sweep every combination of the eight function enables.
    for (int k = 0; k < 256; k++) begin
      rnd38(v); padMgmtEn = v | 38'h3F_0000_F0FF;
      rnd38(v); userOut = v; rnd38(v); userOeb = v; rnd38(v); padIn = v;
      rnd38(v); padOutDis = v;
      seed = nextRand(seed);
      {hkSdo, hkSdoOeb, uartTx, trapIn, coreClk, userClk, spiSck, spiCsb, spiSdo} = seed[24:16];
      uartEnable = k[6]; spiEnable = k[7];
      busWrite(3'd2, 4'h1, {31'd0, k[0]});
      busWrite(3'd3, 4'h1, {29'd0, k[3:1]});
      busWrite(3'd4, 4'h1, {30'd0, k[5:4]});
      busWrite(3'd0, 4'hF, nextRand(seed));
      checkPads("R3 R7 R8 R9 R10");
      if (k % 64 == 0) begin
        readReg("R7", 3'd2, {31'd0, k[0]});
        readReg("R8", 3'd3, {29'd0, k[3:1]});
        readReg("R9", 3'd4, {30'd0, k[5:4]});
      end
    end

    // R11: input disable blocks user, special inputs and readback.
    busWrite(3'd2, 4'h1, 32'd0);
    busWrite(3'd4, 4'h1, 32'd3);
    uartEnable = 1; spiEnable = 1;
    for (int k = 0; k < 16; k++) begin
      rnd38(v); padMgmtEn = v;
      rnd38(v); padInDis = v;
      padIn = '1; #1;
      checkPads("R11");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule